// File: doc/BRIEF.md
# Shared-Select Host Register Port

This block gives a host processor access to a small bank of configuration registers over an asynchronous strobe interface. The host drives an active-low select, an active-low read strobe or write strobe, an 8-bit register address and a 4-bit device address. Each device carries a 4-bit strapped identity. A device answers only when its identity equals the device address. Up to sixteen devices can therefore hang off one select line and one data bus.

The host strobes are brought into the local clock domain through a two-flop synchroniser. The block holds its acknowledge output low from the start of a claimed strobe until the access has completed, and the host stretches the access until acknowledge returns high. Byte lanes on the data bus can be reversed for big-endian hosts. The bus width is a parameter and may be 8, 16 or 32 bits.

An interrupt pending register collects event pulses. A mask register selects which pending bits raise the active-low interrupt line.

Top module: `hostreg_port`

## Requirements
- R1: An access is claimed only while `sel_n` is 0 and `dev_addr` equals `strap_id`. For an unclaimed strobe, `ack` stays 1, the bus is not driven and no register changes.
- R2: Configuration registers sit at register addresses 0 to NUM_CFG-1 (default 4) and are DATA_W bits wide. A claimed write stores the bus value and a later read returns it.
- R3: `ack` goes to 0 as soon as a claimed strobe is asserted. It stays 0 for exactly WAIT_CYC+2 clock periods: two for the synchroniser plus the wait states. It then goes to 1 and stays there until the strobe is released.
- R4: With `big_endian` at 0, bus bits [8i+7:8i] carry register byte i. With `big_endian` at 1, they carry register byte NB-1-i, where NB = DATA_W/8. This mapping applies to both reads and writes.
- R5: The block drives `host_data` only while `sel_n` is 0, `dev_addr` equals `strap_id` and `rd_n` is 0. At all other times the bus is high-impedance.
- R6: A 1 on bit k of `irq_event` in any clock cycle sets bit k of the pending register. The pending register reads at address 0x10, right-aligned and zero-extended.
- R7: Writing to address 0x10 clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R8: The mask register is at address 0x11, and 1 enables a bit. `irq_n` is 0 exactly while some pending bit has its mask bit set.
- R9: Any address that is not a configuration register, 0x10 or 0x11 reads as 0. Writes to such an address change nothing.
- R10: After reset, all registers are 0, `ack` is 1 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Shared select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_addr | input | 8 | Register address |
| dev_addr | input | 4 | Device address compared with the strap |
| strap_id | input | 4 | Strapped identity of this device |
| big_endian | input | 1 | 0: little-endian lanes, 1: reversed lanes |
| host_data | inout | DATA_W | Bidirectional host data bus |
| ack | output | 1 | Access complete; 0 inserts wait states |
| irq_n | output | 1 | Interrupt request, active low |
| irq_event | input | IRQ_W | Event pulses that set pending bits |

## Verification
The bench sweeps all sixteen device addresses against one strap. A device that decoded the identity loosely would store a write meant for another device, or would drop its acknowledge for it. Every configuration register is written under both lane orders and read back under the other. A missing or mirrored swap shows up as a byte-reversed value. The acknowledge-low time is counted against the synchroniser depth plus the wait states, which catches an off-by-one in the sequencer. The bench holds the bus at zero while reading through a foreign identity or with no read strobe, so a driver that leaks onto the bus corrupts the observed value. Pending bits are cleared with mixed one/zero patterns, which exposes a clear that ignores the written data.

// File: rtl/hostreg_pkg.sv
`timescale 1ns/1ps
package hostreg_pkg;
    localparam int REG_AW = 8;
    localparam int DEV_W  = 4;

    localparam logic [REG_AW-1:0] ADDR_PEND = 8'h10;
    localparam logic [REG_AW-1:0] ADDR_MASK = 8'h11;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_DONE = 2'd2
    } hs_state_e;

    // synchronised strobes, converted to active high
    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } strobe_t;
endpackage

// File: rtl/hostreg_sync.sv
`timescale 1ns/1ps
module hostreg_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/hostreg_lanes.sv
`timescale 1ns/1ps
module hostreg_lanes #(
    parameter int DATA_W = 32
) (
    input  logic              swap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign dout[i*8 +: 8] = swap ? din[(NB-1-i)*8 +: 8] : din[i*8 +: 8];
    end
endmodule

// File: rtl/hostreg_handshake.sv
`timescale 1ns/1ps
module hostreg_handshake
    import hostreg_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      claim_s,
    input  strobe_t   stb_s,
    output logic      start,
    output logic      start_wr,
    output logic      done,
    output hs_state_e state
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((WAIT_CYC > 0) ? WAIT_CYC - 1 : 0);

    hs_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic            active_s;

    assign active_s = claim_s & (stb_s.rd | stb_s.wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                HS_IDLE: if (active_s) begin
                    state_q <= (WAIT_CYC == 0) ? HS_DONE : HS_WAIT;
                    cnt_q   <= CNT_LOAD;
                end
                HS_WAIT: begin
                    if (!active_s)        state_q <= HS_IDLE;
                    else if (cnt_q == '0) state_q <= HS_DONE;
                    else                  cnt_q   <= cnt_q - 1'b1;
                end
                HS_DONE: if (!active_s) state_q <= HS_IDLE;
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    assign start    = (state_q == HS_IDLE) & active_s;
    assign start_wr = start & stb_s.wr;
    assign done     = (state_q == HS_DONE);
    assign state    = state_q;
endmodule

// File: rtl/hostreg_regfile.sv
`timescale 1ns/1ps
module hostreg_regfile
    import hostreg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_CFG = 4,
    parameter int IRQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IRQ_W-1:0]  irq_event,
    output logic [DATA_W-1:0] rdata,
    output logic [IRQ_W-1:0]  irq_mask,
    output logic              irq_n
);
    localparam int IDX_W = $clog2(NUM_CFG);

    logic [DATA_W-1:0] cfg_q [NUM_CFG];
    logic [IRQ_W-1:0]  pend_q;
    logic [IRQ_W-1:0]  mask_q;
    logic [IRQ_W-1:0]  clr;
    logic              hit_cfg;

    assign hit_cfg = (int'(addr) < NUM_CFG);
    assign clr     = (wr_en && addr == ADDR_PEND) ? wdata[IRQ_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CFG; i++)
                if (wr_en && int'(addr) == i) cfg_q[i] <= wdata;
            if (wr_en && addr == ADDR_MASK) mask_q <= wdata[IRQ_W-1:0];
            pend_q <= (pend_q & ~clr) | irq_event;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_cfg)                rdata = cfg_q[addr[IDX_W-1:0]];
        else if (addr == ADDR_PEND) rdata[IRQ_W-1:0] = pend_q;
        else if (addr == ADDR_MASK) rdata[IRQ_W-1:0] = mask_q;
    end

    assign irq_mask = mask_q;
    assign irq_n    = ~|(pend_q & mask_q);
endmodule

// File: rtl/hostreg_port.sv
`timescale 1ns/1ps
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_CFG  = 4,
    parameter int IRQ_W    = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [DEV_W-1:0]  strap_id,
    input  logic              big_endian,
    inout  wire  [DATA_W-1:0] host_data,
    output logic              ack,
    output logic              irq_n,
    input  logic [IRQ_W-1:0]  irq_event
);
    logic              id_hit;
    logic              claim_raw;
    logic [2:0]        stb_raw_n;
    logic [2:0]        stb_sync_n;
    strobe_t           stb_s;
    logic              claim_s;
    logic              hs_start;
    logic              hs_start_wr;
    logic              hs_done;
    hs_state_e         hs_state;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_bus;
    logic [IRQ_W-1:0]  irq_mask;
    logic              drive_bus;

    assign id_hit    = (dev_addr == strap_id);
    assign claim_raw = ~sel_n & id_hit;
    assign stb_raw_n = {sel_n, rd_n, wr_n};

    hostreg_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (stb_raw_n),
        .q   (stb_sync_n)
    );

    assign stb_s   = ~stb_sync_n;
    assign claim_s = stb_s.sel & id_hit;

    hostreg_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
        .clk      (clk),
        .rst      (rst),
        .claim_s  (claim_s),
        .stb_s    (stb_s),
        .start    (hs_start),
        .start_wr (hs_start_wr),
        .done     (hs_done),
        .state    (hs_state)
    );

    hostreg_lanes #(.DATA_W(DATA_W)) u_wr_lanes (
        .swap (big_endian),
        .din  (host_data),
        .dout (wr_word)
    );

    hostreg_regfile #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .IRQ_W(IRQ_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (hs_start_wr),
        .addr      (reg_addr),
        .wdata     (wr_word),
        .irq_event (irq_event),
        .rdata     (rd_word),
        .irq_mask  (irq_mask),
        .irq_n     (irq_n)
    );

    hostreg_lanes #(.DATA_W(DATA_W)) u_rd_lanes (
        .swap (big_endian),
        .din  (rd_word),
        .dout (rd_bus)
    );

    assign drive_bus = claim_raw & ~rd_n;
    assign host_data = drive_bus ? rd_bus : {DATA_W{1'bz}};
    assign ack       = ~(claim_raw & (~rd_n | ~wr_n)) | hs_done;

    logic unused_start;
    assign unused_start = hs_start;
endmodule

// File: rtl/hostreg_port_chk.sv
`timescale 1ns/1ps
module hostreg_port_chk
    import hostreg_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic [DEV_W-1:0] dev_addr,
    input logic [DEV_W-1:0] strap_id,
    input logic             ack,
    input logic             irq_n,
    input logic [IRQ_W-1:0] irq_event,
    input logic [IRQ_W-1:0] irq_mask,
    input hs_state_e        hs_state
);
    logic claimed;
    assign claimed = !sel_n && (dev_addr == strap_id) && !(rd_n && wr_n);

    assert_foreign_ack_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_n || dev_addr != strap_id) |-> ack);

    assert_ack_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> claimed);

    assert_done_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (hs_state == HS_DONE && claimed && $past(claimed) && $past(claimed, 2))
        |=> (hs_state == HS_DONE));

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (|(irq_event & irq_mask)) |=> (!irq_n || $changed(irq_mask)));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> irq_n);
endmodule

bind hostreg_port hostreg_port_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .dev_addr  (dev_addr),
    .strap_id  (strap_id),
    .ack       (ack),
    .irq_n     (irq_n),
    .irq_event (irq_event),
    .irq_mask  (irq_mask),
    .hs_state  (hs_state)
);

// File: tb/test_hostreg_port.sv
`timescale 1ns/1ps
module test_hostreg_port;
    localparam int DW   = 32;
    localparam int NCFG = 4;
    localparam int IW   = 8;
    localparam int WC   = 2;
    localparam logic [3:0] MY_ID = 4'h9;

    logic          clk = 0;
    logic          rst = 1;
    logic          sel_n = 1, rd_n = 1, wr_n = 1;
    logic [7:0]    reg_addr = '0;
    logic [3:0]    dev_addr = '0;
    logic          big_endian = 0;
    logic [IW-1:0] irq_event = '0;
    logic          ack, irq_n;
    wire  [DW-1:0] bus;
    logic          tb_oe = 0;
    logic [DW-1:0] tb_dout = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    assign bus = tb_oe ? tb_dout : {DW{1'bz}};

    always #5 clk = ~clk;

    hostreg_port #(.DATA_W(DW), .NUM_CFG(NCFG), .IRQ_W(IW), .WAIT_CYC(WC)) i_hostreg_port (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (sel_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .reg_addr   (reg_addr),
        .dev_addr   (dev_addr),
        .strap_id   (MY_ID),
        .big_endian (big_endian),
        .host_data  (bus),
        .ack        (ack),
        .irq_n      (irq_n),
        .irq_event  (irq_event)
    );

    function automatic logic [DW-1:0] bswap(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW/8; i++) r[i*8 +: 8] = v[(DW/8-1-i)*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // hold strobe for 8 cycles; lowcnt = samples before first ack high
    task automatic host_write(input logic [7:0] a, input logic [3:0] d,
                              input logic [DW-1:0] v, input logic be, output int lowcnt);
        bit seen = 0;
        lowcnt = 0;
        @(negedge clk);
        reg_addr = a; dev_addr = d; big_endian = be;
        tb_dout = v; tb_oe = 1; sel_n = 0; wr_n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ack) seen = 1;
            else if (!seen) lowcnt++;
        end
        wr_n = 1; sel_n = 1; tb_oe = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input logic [7:0] a, input logic [3:0] d, input logic be,
                             input bit hold_zero, output logic [DW-1:0] v, output int lowcnt);
        bit seen = 0;
        lowcnt = 0;
        v = '0;
        @(negedge clk);
        reg_addr = a; dev_addr = d; big_endian = be;
        tb_dout = '0; tb_oe = hold_zero; sel_n = 0; rd_n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ack && !seen) begin
                seen = 1;
                v = bus;
            end else if (!seen) lowcnt++;
        end
        rd_n = 1; sel_n = 1; tb_oe = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] model [NCFG];
        logic [DW-1:0] rv, wv;
        int lc;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10: reset state
        check(ack === 1'b1, "R10 ack after reset", DW'(ack), 1);
        check(irq_n === 1'b1, "R10 irq_n after reset", DW'(irq_n), 1);
        for (int k = 0; k < NCFG; k++) begin
            host_read(8'(k), MY_ID, 0, 0, rv, lc);
            check(rv === '0, "R10 cfg reset value", rv, 0);
            model[k] = '0;
        end

        // R2 R3 R4: every cfg register under both lane orders
        for (int k = 0; k < NCFG; k++) begin
            for (int be = 0; be < 2; be++) begin
                wv = 32'h1122_3344 + DW'(k) * 32'h0101_0101 + DW'(be) * 32'h4000_0080;
                host_write(8'(k), MY_ID, wv, 1'(be), lc);
                check(lc == WC + 2, "R3 write ack low time", DW'(lc), DW'(WC + 2));
                model[k] = be ? bswap(wv) : wv;
                host_read(8'(k), MY_ID, 0, 0, rv, lc);
                check(lc == WC + 2, "R3 read ack low time", DW'(lc), DW'(WC + 2));
                check(rv === model[k], "R2 R4 little-endian readback", rv, model[k]);
                host_read(8'(k), MY_ID, 1, 0, rv, lc);
                check(rv === bswap(model[k]), "R4 big-endian readback", rv, bswap(model[k]));
            end
        end

        // R1: sweep all device addresses
        for (int d = 0; d < 16; d++) begin
            wv = 32'hA500_0000 | DW'(d);
            host_write(8'h00, 4'(d), wv, 0, lc);
            if (4'(d) == MY_ID) begin
                model[0] = wv;
                check(lc == WC + 2, "R1 own id ack low", DW'(lc), DW'(WC + 2));
            end else begin
                check(lc == 0, "R1 foreign id ack stays high", DW'(lc), 0);
            end
            host_read(8'h00, MY_ID, 0, 0, rv, lc);
            check(rv === model[0], "R1 write claimed only on id match", rv, model[0]);
        end

        // R5: bus released for foreign id and without read strobe
        host_read(8'h00, 4'(MY_ID + 1), 0, 1, rv, lc);
        check(rv === '0, "R5 no drive for foreign id", rv, 0);
        @(negedge clk);
        reg_addr = 8'h00; dev_addr = MY_ID; tb_dout = '0; tb_oe = 1; sel_n = 0;
        repeat (6) @(negedge clk);
        check(bus === '0, "R5 no drive without read strobe", bus, 0);
        sel_n = 1; tb_oe = 0;
        repeat (4) @(negedge clk);

        // R9: unmapped address
        host_write(8'h20, MY_ID, 32'hDEAD_BEEF, 0, lc);
        host_read(8'h20, MY_ID, 0, 0, rv, lc);
        check(rv === '0, "R9 unmapped reads zero", rv, 0);
        for (int k = 0; k < NCFG; k++) begin
            host_read(8'(k), MY_ID, 0, 0, rv, lc);
            check(rv === model[k], "R9 cfg untouched by unmapped write", rv, model[k]);
        end

        // R6 R7 R8: interrupt pending and mask
        @(negedge clk); irq_event = 8'h05;
        @(negedge clk); irq_event = 8'h00;
        host_read(8'h10, MY_ID, 0, 0, rv, lc);
        check(rv === 32'h05, "R6 pending captured", rv, 32'h05);
        check(irq_n === 1'b1, "R8 masked pending keeps irq_n high", DW'(irq_n), 1);
        host_write(8'h11, MY_ID, 32'h04, 0, lc);
        check(irq_n === 1'b0, "R8 unmasked pending drives irq_n low", DW'(irq_n), 0);
        host_read(8'h11, MY_ID, 0, 0, rv, lc);
        check(rv === 32'h04, "R8 mask readback", rv, 32'h04);
        host_write(8'h10, MY_ID, 32'h0000_00F4, 0, lc);
        host_read(8'h10, MY_ID, 0, 0, rv, lc);
        check(rv === 32'h01, "R7 write one clears only those bits", rv, 32'h01);
        check(irq_n === 1'b1, "R8 irq_n released after clear", DW'(irq_n), 1);
        host_write(8'h10, MY_ID, 32'h0, 0, lc);
        host_read(8'h10, MY_ID, 0, 0, rv, lc);
        check(rv === 32'h01, "R7 write zero keeps pending", rv, 32'h01);
        host_write(8'h11, MY_ID, 32'h01, 0, lc);
        check(irq_n === 1'b0, "R8 second mask bit raises irq", DW'(irq_n), 0);
        host_write(8'h10, MY_ID, 32'h01, 0, lc);
        check(irq_n === 1'b1, "R7 clear drops irq", DW'(irq_n), 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule